// File: doc/BRIEF.md
# Sectored Data Cache with Conditional Burst Refill

This block is a small direct-mapped data cache that sits between a 32-bit processor load/store port and a slower main-memory bus. It holds 256 bytes as sixteen lines. Each line carries one tag and four longword sectors, and every sector has its own valid bit. A read that hits returns cached data one cycle after it is accepted and causes no memory traffic.

A read miss refills a whole line only when the addressed line holds no valid sector at all. In that case the cache requests a four-beat burst. The burst starts at the requested longword and wraps modulo four. It continues only while the memory side keeps acknowledging burst capability. Every other miss fetches only the requested longword. As a result, the cache stays correct and useful on a memory system that never grants bursts.

Writes go through to memory and never allocate a line. A cache-enable input of zero turns every access into a plain single memory cycle. A flush input invalidates the whole cache, which makes every line eligible for a burst again.

Top module: `dcache_sector`

## Requirements
- R1: After synchronous reset, `busy`, `cpu_ready` and `mem_req` are low, and every sector is invalid, so the first read of any address misses.
- R2: A cached read that hits raises `cpu_ready` with the cached data on the cycle after acceptance, leaves `busy` low and issues no memory cycle.
- R3: Address bits [3:2] pick the sector, bits [7:4] pick the line and bits [31:8] form the tag. A read hits only when the stored tag equals the address tag and that sector's valid bit is set.
- R4: A cached read miss on a line whose four valid bits are all clear raises `mem_burst` on its first beat. Beat k reads sector (requested sector + k) mod 4 of the same line.
- R5: Each burst beat fills its sector. The beat on which `mem_burst_ack` is low is the last one, so a low acknowledge on the first beat leaves only the requested sector valid. A burst never exceeds four beats.
- R6: A cached read miss on a line with matching tag and at least one valid sector performs one memory read with `mem_burst` low, and validates only the requested sector.
- R7: A cached read miss with a tag mismatch on a line holding valid sectors clears that line's valid bits, loads the new tag and fetches only the requested sector, so the line's former contents miss afterwards.
- R8: During a refill the CPU receives `cpu_ready` and data on the first beat. `busy` stays high until the last beat has been taken.
- R9: Every write is one memory cycle with `mem_we` high and `mem_burst` low, and `cpu_ready` follows its acknowledge. A cached write whose tag matches a line with any valid sector updates that sector and sets its valid bit. Any other write leaves the cache unchanged.
- R10: `flush` while not busy clears every valid bit in one cycle, and a `cpu_req` in that same cycle is ignored. The next miss on any line is burst-eligible.
- R11: A request with `cache_en` low becomes a single memory read or write that neither looks up, fills nor updates the cache. A later cached read still sees the cache's own earlier content.
- R12: While `mem_req` is high and `mem_ack` has not arrived, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | 1 = cached access, 0 = bypass; sampled with the request |
| flush | input | 1 | Invalidate all sectors (honoured when not busy) |
| cpu_req | input | 1 | One-cycle request strobe, accepted when `busy` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Longword byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A memory cycle is in progress; requests are not accepted |
| mem_req | output | 1 | Memory cycle request, held until the last beat |
| mem_we | output | 1 | Memory write |
| mem_burst | output | 1 | Cache asks for a line burst |
| mem_addr | output | 32 | Address of the current beat |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat acknowledge |
| mem_burst_ack | input | 1 | Memory can continue the burst past this beat |

## Verification
The hardest state to reach is a line that is partly valid, because that decides whether a miss bursts or fetches a single sector. No port reveals it directly. The bench builds such lines on purpose. It runs bursts cut short by withdrawing burst acknowledge after zero or one beat, it evicts lines through tag conflicts, and it uses write hits on live lines. It keeps an arithmetic model of every tag, valid bit and cached word, and then predicts the beat count, the burst request and the wrap order of each later miss. A stale cached word left behind by a bypass write is also produced deliberately, to show that bypass leaves the cache untouched.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int WORDS     = 4;
    localparam int LINES     = 16;
    localparam int BYTE_BITS = $clog2(DATA_W / 8);
    localparam int WORD_BITS = $clog2(WORDS);
    localparam int LINE_BITS = $clog2(LINES);
    localparam int TAG_W     = ADDR_W - LINE_BITS - WORD_BITS - BYTE_BITS;

    typedef struct packed {
        logic [TAG_W-1:0]     tag;
        logic [LINE_BITS-1:0] line;
        logic [WORD_BITS-1:0] word;
        logic [BYTE_BITS-1:0] byte_off;
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_SINGLE
    } state_e;
endpackage

// File: rtl/dcache_tags.sv
module dcache_tags
    import dcache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic [LINE_BITS-1:0] rd_line_i,
    output logic [TAG_W-1:0]     tag_o,
    output logic [WORDS-1:0]     vld_o,
    input  logic                 ld_i,
    input  logic [LINE_BITS-1:0] ld_line_i,
    input  logic [TAG_W-1:0]     ld_tag_i,
    input  logic                 set_i,
    input  logic [LINE_BITS-1:0] set_line_i,
    input  logic [WORD_BITS-1:0] set_word_i
);
    logic [WORDS-1:0] vld_a [LINES];
    logic [TAG_W-1:0] tag_a [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [WORDS-1:0] v_q;
        logic [TAG_W-1:0] t_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= '0;
                t_q <= '0;
            end else if (flush_i) begin
                v_q <= '0;
            end else begin
                if (ld_i && ld_line_i == LINE_BITS'(g)) begin
                    v_q <= '0;
                    t_q <= ld_tag_i;
                end
                if (set_i && set_line_i == LINE_BITS'(g))
                    v_q[set_word_i] <= 1'b1;
            end
        end
        assign vld_a[g] = v_q;
        assign tag_a[g] = t_q;
    end

    assign vld_o = vld_a[rd_line_i];
    assign tag_o = tag_a[rd_line_i];

    logic any_vld;
    always_comb begin
        any_vld = 1'b0;
        for (int i = 0; i < LINES; i++) any_vld = any_vld | (|vld_a[i]);
    end

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !any_vld);
endmodule

// File: rtl/dcache_data.sv
module dcache_data
    import dcache_pkg::*;
(
    input  logic                 clk,
    input  logic                 we_i,
    input  logic [LINE_BITS-1:0] wr_line_i,
    input  logic [WORD_BITS-1:0] wr_word_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [LINE_BITS-1:0] rd_line_i,
    input  logic [WORD_BITS-1:0] rd_word_i,
    output logic [DATA_W-1:0]    rd_data_o
);
    logic [DATA_W-1:0] store_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (we_i) store_q[wr_line_i][wr_word_i] <= wr_data_i;
    end

    assign rd_data_o = store_q[rd_line_i][rd_word_i];
endmodule

// File: rtl/dcache_sector.sv
module dcache_sector
    import dcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_burst_ack
);
    state_e               state_q;
    addr_t                req_q;
    addr_t                cpu_a;
    logic                 we_q;
    logic                 burst_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [WORD_BITS-1:0] word_q;
    logic [WORD_BITS-1:0] beat_q;

    logic [TAG_W-1:0]     look_tag;
    logic [WORDS-1:0]     look_vld;
    logic [DATA_W-1:0]    look_data;
    logic                 tag_eq, line_live, rd_hit, wr_hit;
    logic                 in_idle, take, flush_clr, ld_tag, set_en, fill_last;
    logic [LINE_BITS-1:0] set_line;
    logic [WORD_BITS-1:0] set_word;
    logic [DATA_W-1:0]    set_data;

    assign cpu_a     = addr_t'(cpu_addr);
    assign in_idle   = (state_q == ST_IDLE);
    assign take      = in_idle && cpu_req && !flush;
    assign flush_clr = in_idle && flush;

    assign tag_eq    = (look_tag == cpu_a.tag);
    assign line_live = |look_vld;
    assign rd_hit    = tag_eq && look_vld[cpu_a.word];
    assign wr_hit    = tag_eq && line_live;

    assign ld_tag    = take && cache_en && !cpu_we && !rd_hit && !tag_eq;
    assign set_en    = (take && cache_en && cpu_we && wr_hit) ||
                       (state_q == ST_FILL && mem_ack);
    assign set_line  = in_idle ? cpu_a.line  : req_q.line;
    assign set_word  = in_idle ? cpu_a.word  : word_q;
    assign set_data  = in_idle ? cpu_wdata   : mem_rdata;
    assign fill_last = !burst_q || !mem_burst_ack || (beat_q == WORD_BITS'(WORDS - 1));

    dcache_tags u_tags (
        .clk       (clk),
        .rst       (rst),
        .flush_i   (flush_clr),
        .rd_line_i (cpu_a.line),
        .tag_o     (look_tag),
        .vld_o     (look_vld),
        .ld_i      (ld_tag),
        .ld_line_i (cpu_a.line),
        .ld_tag_i  (cpu_a.tag),
        .set_i     (set_en),
        .set_line_i(set_line),
        .set_word_i(set_word)
    );

    dcache_data u_data (
        .clk       (clk),
        .we_i      (set_en),
        .wr_line_i (set_line),
        .wr_word_i (set_word),
        .wr_data_i (set_data),
        .rd_line_i (cpu_a.line),
        .rd_word_i (cpu_a.word),
        .rd_data_o (look_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            req_q     <= '0;
            we_q      <= 1'b0;
            burst_q   <= 1'b0;
            wdata_q   <= '0;
            word_q    <= '0;
            beat_q    <= '0;
            cpu_ready <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_ready <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        req_q   <= cpu_a;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                        word_q  <= cpu_a.word;
                        beat_q  <= '0;
                        burst_q <= 1'b0;
                        if (!cache_en || cpu_we) begin
                            state_q <= ST_SINGLE;
                        end else if (rd_hit) begin
                            cpu_ready <= 1'b1;
                            cpu_rdata <= look_data;
                        end else begin
                            state_q <= ST_FILL;
                            burst_q <= !line_live;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        if (beat_q == '0) begin
                            cpu_ready <= 1'b1;
                            cpu_rdata <= mem_rdata;
                        end
                        if (fill_last) begin
                            state_q <= ST_IDLE;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                            word_q <= word_q + 1'b1;
                        end
                    end
                end
                ST_SINGLE: begin
                    if (mem_ack) begin
                        cpu_ready <= 1'b1;
                        cpu_rdata <= we_q ? '0 : mem_rdata;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = !in_idle;
    assign mem_req   = !in_idle;
    assign mem_we    = (state_q == ST_SINGLE) && we_q;
    assign mem_burst = (state_q == ST_FILL) && burst_q;
    assign mem_addr  = (state_q == ST_FILL) ?
                       {req_q.tag, req_q.line, word_q, {BYTE_BITS{1'b0}}} : req_q;
    assign mem_wdata = wdata_q;

    assert_bus_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    assert_write_single_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !mem_burst);

    assert_burst_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_burst && mem_ack && !mem_burst_ack) |=> !busy);

    assert_first_beat_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && mem_ack && beat_q == '0) |=> cpu_ready);

    assert_hit_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (take && cache_en && !cpu_we && rd_hit) |=> (cpu_ready && !busy));
endmodule

// File: tb/dcache_sector_test.sv
`timescale 1ns/1ps
module dcache_sector_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_en = 1'b1, flush = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready, busy, mem_req, mem_we, mem_burst;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0, mem_burst_ack = 1'b0;

    always #2 clk = ~clk;

    dcache_sector uut (
        .clk(clk), .rst(rst), .cache_en(cache_en), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_burst_ack(mem_burst_ack)
    );

    int tests = 0, fails = 0, cyc = 0;

    // bench model of memory and cache state
    logic [31:0] mm [256];
    logic [23:0] tm [16];
    logic [3:0]  vm [16];
    logic [31:0] cd [16][4];

    int   ba_cfg = 4, lat_cfg = 1;
    int   wcnt = 0, bidx = 0, tx_beats = 0;
    logic [1:0] tx_word [4];
    logic [3:0] tx_line [4];
    logic tx_burst = 1'b0, tx_we = 1'b0, hold_bad = 1'b0, prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R1 watchdog expired: actual %0d expected below %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // memory responder, drives at falling edges
    always @(negedge clk) begin
        if (mem_req && prev_wait && mem_addr != prev_addr) hold_bad = 1'b1;
        if (!mem_req) begin
            mem_ack = 1'b0; mem_burst_ack = 1'b0; wcnt = 0; bidx = 0;
        end else if (wcnt < lat_cfg) begin
            mem_ack = 1'b0; mem_burst_ack = 1'b0; wcnt++;
        end else begin
            mem_ack = 1'b1;
            mem_burst_ack = (bidx < ba_cfg);
            mem_rdata = mm[mem_addr[9:2]];
            if (mem_we) mm[mem_addr[9:2]] = mem_wdata;
            if (tx_beats == 0) begin tx_burst = mem_burst; tx_we = mem_we; end
            if (tx_beats < 4) begin
                tx_word[tx_beats] = mem_addr[3:2];
                tx_line[tx_beats] = mem_addr[7:4];
            end
            tx_beats++; bidx++;
        end
        prev_wait = mem_req && !mem_ack;
        prev_addr = mem_addr;
    end

    task automatic access(input bit we, input bit en, input logic [31:0] a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int cr, output bit busy_rdy);
        tx_beats = 0; hold_bad = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cache_en = en; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0; cr = 1;
        while (!cpu_ready && cr < 100) begin @(negedge clk); cr++; end
        rd = cpu_rdata; busy_rdy = busy;
        for (int g = 0; g < 100 && busy; g++) @(negedge clk);
    endtask

    task automatic rd_chk(input int tg, input int ln, input int wd, input bit en);
        logic [31:0] a, rd, expd;
        int cr, eb, nb;
        bit br, hit, elig;
        string rq;
        a = {22'd0, tg[1:0], ln[3:0], wd[1:0], 2'b00};
        hit  = en && tm[ln] == 24'(tg) && vm[ln][wd];
        elig = en && !hit && vm[ln] == 4'b0;
        nb   = (ba_cfg + 1 > 4) ? 4 : ba_cfg + 1;
        eb   = !en ? 1 : hit ? 0 : elig ? nb : 1;
        expd = hit ? cd[ln][wd] : mm[a[9:2]];
        rq   = !en ? "R11" : hit ? "R2" : elig ? "R4" :
               (tm[ln] != 24'(tg)) ? "R7" : "R6";
        access(1'b0, en, a, 32'd0, rd, cr, br);
        chk(rd == expd, rq, "read data", rd, expd);
        chk(tx_beats == eb, en ? "R3" : "R11", "memory beat count", 32'(tx_beats), 32'(eb));
        if (hit) chk(cr == 1, "R2", "hit latency", 32'(cr), 32'd1);
        if (eb > 0) chk(tx_burst == elig, elig ? "R4" : "R6", "burst request", 32'(tx_burst), 32'(elig));
        if (elig) begin
            chk(tx_beats == nb, "R5", "burst length vs ack", 32'(tx_beats), 32'(nb));
            for (int k = 0; k < 4 && k < tx_beats; k++) begin
                chk(tx_word[k] == 2'(wd + k) && tx_line[k] == 4'(ln), "R4", "wrap order",
                    {tx_line[k], tx_word[k]}, {4'(ln), 2'(wd + k)});
            end
        end
        if (eb > 0) chk(br == (eb > 1), "R8", "busy at ready", 32'(br), 32'(eb > 1));
        if (lat_cfg > 0 && eb > 0) chk(!hold_bad, "R12", "address hold", 32'(hold_bad), 32'd0);
        if (en && !hit) begin
            if (tm[ln] != 24'(tg)) begin vm[ln] = 4'b0; tm[ln] = 24'(tg); end
            for (int k = 0; k < tx_beats && k < 4; k++) begin
                vm[ln][2'(wd + k)] = 1'b1;
                cd[ln][2'(wd + k)] = mm[{tg[1:0], ln[3:0], 2'(wd + k)}];
            end
        end
    endtask

    task automatic wr_chk(input int tg, input int ln, input int wd, input bit en,
                          input logic [31:0] val);
        logic [31:0] a, rd;
        int cr;
        bit br, hit;
        a = {22'd0, tg[1:0], ln[3:0], wd[1:0], 2'b00};
        hit = en && tm[ln] == 24'(tg) && (vm[ln] != 4'b0);
        access(1'b1, en, a, val, rd, cr, br);
        chk(tx_beats == 1 && tx_we && !tx_burst, en ? "R9" : "R11", "single write cycle",
            {30'd0, tx_we, tx_burst}, 32'd2);
        chk(mm[a[9:2]] == val, "R9", "memory written", mm[a[9:2]], val);
        if (lat_cfg > 0) chk(!hold_bad, "R12", "write hold", 32'(hold_bad), 32'd0);
        if (hit) begin vm[ln][wd] = 1'b1; cd[ln][wd] = val; end
    endtask

    task automatic do_flush(input bit with_req);
        @(negedge clk);
        flush = 1'b1; cpu_req = with_req; cpu_we = 1'b0; cache_en = 1'b1;
        cpu_addr = 32'h0000_0354;
        @(negedge clk);
        flush = 1'b0; cpu_req = 1'b0;
        chk(!busy && !cpu_ready && !mem_req, "R10", "request ignored during flush",
            {29'd0, busy, cpu_ready, mem_req}, 32'd0);
        @(negedge clk);
        chk(!busy && !cpu_ready, "R10", "still idle after flush", {30'd0, busy, cpu_ready}, 32'd0);
        for (int l = 0; l < 16; l++) vm[l] = 4'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mm[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
        for (int l = 0; l < 16; l++) begin tm[l] = '0; vm[l] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !cpu_ready && !mem_req, "R1", "reset outputs",
            {29'd0, busy, cpu_ready, mem_req}, 32'd0);

        // full bursts, then hits on every sector
        ba_cfg = 4; lat_cfg = 1;
        for (int l = 0; l < 16; l++) rd_chk(0, l, l % 4, 1'b1);
        for (int l = 0; l < 16; l++)
            for (int w = 0; w < 4; w++) rd_chk(0, l, w, 1'b1);

        // tag conflicts and partial lines, no burst support
        ba_cfg = 0;
        for (int l = 0; l < 8; l++) begin
            rd_chk(1, l, (l + 1) % 4, 1'b1);
            rd_chk(0, l, l % 4, 1'b1);
            rd_chk(0, l, (l + 2) % 4, 1'b1);
            rd_chk(0, l, (l + 2) % 4, 1'b1);
        end

        // flush with simultaneous request, then truncated bursts
        do_flush(1'b1);
        lat_cfg = 0; ba_cfg = 1;
        for (int l = 0; l < 8; l++) begin rd_chk(2, l, 3, 1'b1); rd_chk(2, l, 0, 1'b1); end
        ba_cfg = 0;
        for (int l = 8; l < 16; l++) begin rd_chk(3, l, l % 4, 1'b1); rd_chk(3, l, (l + 1) % 4, 1'b1); end

        // write-through
        lat_cfg = 2; ba_cfg = 4;
        wr_chk(2, 0, 3, 1'b1, 32'hDEAD_0003);
        rd_chk(2, 0, 3, 1'b1);
        wr_chk(2, 0, 1, 1'b1, 32'hBEEF_0001);
        rd_chk(2, 0, 1, 1'b1);
        wr_chk(3, 5, 0, 1'b1, 32'hCAFE_0500);
        rd_chk(3, 5, 0, 1'b1);
        rd_chk(3, 5, 0, 1'b1);

        // bypass
        rd_chk(2, 0, 3, 1'b0);
        wr_chk(2, 0, 3, 1'b0, 32'h1234_5678);
        rd_chk(2, 0, 3, 1'b1);
        rd_chk(1, 9, 2, 1'b0);
        rd_chk(1, 9, 2, 1'b1);

        // longer latency sweep after plain flush
        do_flush(1'b0);
        lat_cfg = 3; ba_cfg = 4;
        for (int l = 0; l < 16; l++) begin
            rd_chk(1, l, (l * 3) % 4, 1'b1);
            rd_chk(1, l, (l * 3 + 2) % 4, 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule